// File: doc/BRIEF.md
# Configurable Serial Port Format Engine

This block is an asynchronous serial transmitter and receiver pair. A 16-bit setup word sets the bit rate and the character layout. The layout covers data width, stop-bit count and parity mode. A second 16-bit word holds a transmit delay as four BCD digits. The setup and delay inputs are decoded and checked continuously. Any field that is out of range is replaced by a fixed safe value, and a sticky error flag is raised.

The decoded configuration is captured only while both directions are idle, so a character in flight never changes format. Each accepted transmit byte first waits out the programmed delay in 10 ms units and is then sent. The receiver oversamples the line sixteen times per bit and takes a three-sample majority vote. It reports each character with parity and framing error flags.

Top module: `serial_fmt_engine`

## Requirements
- R1: `setup_i[7:0]` selects the bit rate: 0x00 gives 1200, 0x01 gives 2400, 0x02 gives 4800, 0x03 gives 9600 and 0x04 gives 19200 bit/s. One bit lasts 16 × SAMPLE_DIV × 2^(4−code) clock cycles. Any other code runs at 9600 bit/s and sets `err_o`.
- R2: `setup_i[15:8]` is a format code from 0x00 to 0x0B. Codes 0x00–0x05 carry 7 data bits and codes 0x06–0x0B carry 8 data bits. Within each group of six, the offsets 0..5 mean: one stop bit with even, odd or no parity, then two stop bits with even, odd or no parity. Every frame has one low start bit, then data LSB first, then the parity bit if any, then high stop bits.
- R3: A format code above 0x0B sends and receives 7 data bits, even parity and 2 stop bits, and sets `err_o`.
- R4: After a byte is accepted on `tx_valid_i`/`tx_ready_o`, the start bit begins after N × TICK_DIV cycles (N is the BCD value of `delay_i`, 0–9999; one unit is nominally 10 ms). The delay before the next sample tick is added to this.
- R5: If any nibble of `delay_i` is above 9, the delay is zero and `err_o` is set.
- R6: `err_o` stays high until `err_clr_i` is pulsed while both setup fields and the delay word are legal.
- R7: The receiver decides each bit by a majority of oversamples 7, 8 and 9 out of 16, so one corrupted sample is rejected. On a parity mismatch it pulses `rx_valid_o` with `rx_perr_o` high.
- R8: A low first stop bit gives a one-cycle `rx_valid_o` with `rx_ferr_o` high. The error flags are high only together with `rx_valid_o`.
- R9: A low pulse that is not low by majority at mid-start-bit is discarded without `rx_valid_o`.
- R10: A change to the setup word while a character is in flight does not alter that character.
- R11: `tx_o` is high whenever `tx_ready_o` is high. In 7-bit formats `tx_data_i[7]` is ignored and `rx_data_o[7]` is 0. After reset `tx_o`=1, `tx_ready_o`=1, `err_o`=0 and `rx_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 16 | Rate code [7:0], format code [15:8] |
| delay_i | input | 16 | Transmit delay, four BCD digits |
| err_clr_i | input | 1 | Clears the sticky setup error |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_data_i | input | 8 | Transmit byte |
| tx_ready_o | output | 1 | Transmitter idle, byte taken when valid |
| tx_o | output | 1 | Serial output, idle high |
| rx_i | input | 1 | Serial input |
| rx_valid_o | output | 1 | One-cycle pulse per received character |
| rx_data_o | output | 8 | Received byte |
| rx_perr_o | output | 1 | Parity mismatch on this character |
| rx_ferr_o | output | 1 | Stop bit low on this character |
| err_o | output | 1 | Sticky setup error |

## Verification
The hardest case to reach from the ports is a setup change that lands in the middle of a frame. It must be held off until both directions have gone idle. The bench starts an 8N1 character and then switches the setup word to a slower 7E2 format partway through the frame. It then checks the sampled bit pattern and the start-to-ready time against the old format. Single-sample line glitches are driven straight onto `rx_i` with loopback off. One glitch lands inside a data bit and another is a short low pulse that imitates a start bit. Together they exercise the majority vote and start rejection.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2} par_e;

  typedef struct packed {
    logic [2:0] rate;
    logic       eight;
    logic       two_stop;
    par_e       par;
  } cfg_t;

  localparam logic [2:0]  RATE_FALLBACK = 3'd3;
  localparam logic [2:0]  RATE_MAX      = 3'd4;
  localparam int unsigned FMT_CODES     = 12;
  localparam int unsigned MAX_FRAME     = 12;
  localparam int unsigned OVS           = 16;

  // start + data + parity + stop(s)
  function automatic logic [3:0] frame_len(cfg_t c);
    return 4'd2 + (c.eight ? 4'd8 : 4'd7) + {3'd0, c.par != PAR_NONE} + {3'd0, c.two_stop};
  endfunction
endpackage

// File: rtl/sfe_cfg_decode.sv
module sfe_cfg_decode
  import sfe_pkg::*;
(
  input  logic [15:0] setup_i,
  input  logic [15:0] delay_i,
  output cfg_t        cfg_o,
  output logic [13:0] delay_units_o,
  output logic        bad_o
);
  logic [7:0] rate_code, fmt_code;
  logic       rate_bad, fmt_bad, bcd_bad;
  logic [2:0] grp_idx;

  always_comb begin
    rate_code = setup_i[7:0];
    fmt_code  = setup_i[15:8];
    rate_bad  = rate_code > 8'(RATE_MAX);
    fmt_bad   = fmt_code >= 8'(FMT_CODES);
    grp_idx   = '0;
    cfg_o.rate = rate_bad ? RATE_FALLBACK : rate_code[2:0];
    if (fmt_bad) begin
      cfg_o.eight    = 1'b0;
      cfg_o.two_stop = 1'b1;
      cfg_o.par      = PAR_EVEN;
    end else begin
      cfg_o.eight    = fmt_code >= 8'd6;
      grp_idx        = cfg_o.eight ? 3'(fmt_code - 8'd6) : fmt_code[2:0];
      cfg_o.two_stop = grp_idx >= 3'd3;
      case (grp_idx)
        3'd0, 3'd3: cfg_o.par = PAR_EVEN;
        3'd1, 3'd4: cfg_o.par = PAR_ODD;
        default:    cfg_o.par = PAR_NONE;
      endcase
    end
    bcd_bad = 1'b0;
    for (int i = 0; i < 4; i++)
      if (delay_i[4*i +: 4] > 4'd9) bcd_bad = 1'b1;
    delay_units_o = bcd_bad ? 14'd0 :
                    14'(delay_i[15:12]) * 14'd1000 + 14'(delay_i[11:8]) * 14'd100 +
                    14'(delay_i[7:4]) * 14'd10 + 14'(delay_i[3:0]);
    bad_o = rate_bad | fmt_bad | bcd_bad;
  end
endmodule

// File: rtl/sfe_baud_gen.sv
module sfe_baud_gen #(
  parameter  int unsigned SAMPLE_DIV = 407,
  localparam int unsigned CW         = $clog2(SAMPLE_DIV * 16 + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] rate_i,
  output logic       tick_o
);
  logic [CW-1:0] cnt, lim;

  // slower rates stretch the 19200 sample period by powers of two
  assign lim    = CW'((SAMPLE_DIV << (32'd4 - {29'd0, rate_i})) - 32'd1);
  assign tick_o = cnt >= lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
  import sfe_pkg::*;
#(
  parameter  int unsigned TICK_DIV = 1250000,
  localparam int unsigned PW       = $clog2(TICK_DIV + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  cfg_t        cfg_i,
  input  logic [13:0] delay_units_i,
  input  logic        valid_i,
  input  logic [7:0]  data_i,
  output logic        ready_o,
  output logic        tx_o
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} st_e;

  st_e                  st;
  logic [PW-1:0]        pre;
  logic [13:0]          units;
  logic [MAX_FRAME-1:0] sreg, frame;
  logic [3:0]           left, sub;
  logic [7:0]           dmask;
  logic                 pbit, has_par;

  always_comb begin
    dmask   = cfg_i.eight ? data_i : {1'b0, data_i[6:0]};
    has_par = cfg_i.par != PAR_NONE;
    pbit    = (^dmask) ^ (cfg_i.par == PAR_ODD);
    frame    = '1;
    frame[0] = 1'b0;
    if (cfg_i.eight) begin
      frame[8:1] = data_i;
      if (has_par) frame[9] = pbit;
    end else begin
      frame[7:1] = data_i[6:0];
      if (has_par) frame[8] = pbit;
    end
  end

  assign ready_o = st == S_IDLE;
  assign tx_o    = (st == S_SHIFT) ? sreg[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= S_IDLE;
      pre   <= '0;
      units <= '0;
      sreg  <= '1;
      left  <= '0;
      sub   <= '0;
    end else begin
      case (st)
        S_IDLE: if (valid_i) begin
          sreg  <= frame;
          left  <= frame_len(cfg_i);
          units <= delay_units_i;
          pre   <= '0;
          st    <= S_WAIT;
        end
        S_WAIT: begin
          if (units != '0) begin
            if (pre == PW'(TICK_DIV - 1)) begin
              pre   <= '0;
              units <= units - 1'b1;
            end else begin
              pre <= pre + 1'b1;
            end
          end else if (tick_i) begin
            sub <= '0;
            st  <= S_SHIFT;
          end
        end
        S_SHIFT: if (tick_i) begin
          sub <= sub + 1'b1;
          if (sub == 4'(OVS - 1)) begin
            if (left == 4'd1) st <= S_IDLE;
            else begin
              sreg <= {1'b1, sreg[MAX_FRAME-1:1]};
              left <= left - 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
  import sfe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  cfg_t       cfg_i,
  input  logic       rx_i,
  output logic       idle_o,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       ferr_o
);
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} st_e;

  st_e        st;
  logic [1:0] sync;
  logic       line, maj, has_par, rpb, rstop;
  logic [3:0] sub, idx, nrx;
  logic [2:0] votes;
  logic [9:0] sreg, nxt, al;
  logic [7:0] rdat;

  assign line    = sync[1];
  assign idle_o  = st == R_IDLE;
  assign maj     = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
  assign has_par = cfg_i.par != PAR_NONE;
  assign nrx     = (cfg_i.eight ? 4'd8 : 4'd7) + {3'd0, has_par} + 4'd1;

  always_comb begin
    nxt   = {maj, sreg[9:1]};
    al    = nxt >> (4'd10 - nrx);
    rdat  = cfg_i.eight ? al[7:0] : {1'b0, al[6:0]};
    rpb   = cfg_i.eight ? al[8] : al[7];
    rstop = al[4'(nrx - 4'd1)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync    <= 2'b11;
      st      <= R_IDLE;
      sub     <= '0;
      idx     <= '0;
      votes   <= '1;
      sreg    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      sync    <= {sync[0], rx_i};
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      if (tick_i) begin
        if (st == R_IDLE) begin
          if (!line) begin
            st  <= R_START;
            sub <= 4'd1;
          end
        end else begin
          sub <= sub + 1'b1;
          if (sub >= 4'd7 && sub <= 4'd9) votes[2'(sub - 4'd7)] <= line;
          if (sub == 4'(OVS - 1)) begin
            if (st == R_START) begin
              idx <= '0;
              st  <= maj ? R_IDLE : R_BITS;
            end else begin
              sreg <= nxt;
              if (idx == nrx - 4'd1) begin
                st      <= R_IDLE;
                valid_o <= 1'b1;
                data_o  <= rdat;
                perr_o  <= has_par & ((^rdat) ^ rpb ^ (cfg_i.par == PAR_ODD));
                ferr_o  <= ~rstop;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_fmt_engine.sv
module serial_fmt_engine
  import sfe_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = 407,
  parameter int unsigned TICK_DIV   = 1250000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] setup_i,
  input  logic [15:0] delay_i,
  input  logic        err_clr_i,
  input  logic        tx_valid_i,
  input  logic [7:0]  tx_data_i,
  output logic        tx_ready_o,
  output logic        tx_o,
  input  logic        rx_i,
  output logic        rx_valid_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_perr_o,
  output logic        rx_ferr_o,
  output logic        err_o
);
  cfg_t        cfg_d, cfg_q;
  logic [13:0] units_d, units_q;
  logic        cfg_bad, latch_en, rx_idle, tick;

  sfe_cfg_decode u_dec (
    .setup_i      (setup_i),
    .delay_i      (delay_i),
    .cfg_o        (cfg_d),
    .delay_units_o(units_d),
    .bad_o        (cfg_bad)
  );

  assign latch_en = tx_ready_o & rx_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '{rate: RATE_FALLBACK, eight: 1'b1, two_stop: 1'b0, par: PAR_NONE};
      units_q <= '0;
      err_o   <= 1'b0;
    end else begin
      if (latch_en) begin
        cfg_q   <= cfg_d;
        units_q <= units_d;
      end
      if (err_clr_i)                err_o <= 1'b0;
      else if (latch_en && cfg_bad) err_o <= 1'b1;
    end
  end

  sfe_baud_gen #(.SAMPLE_DIV(SAMPLE_DIV)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rate_i(cfg_q.rate),
    .tick_o(tick)
  );

  sfe_tx #(.TICK_DIV(TICK_DIV)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .cfg_i        (cfg_q),
    .delay_units_i(units_q),
    .valid_i      (tx_valid_i),
    .data_i       (tx_data_i),
    .ready_o      (tx_ready_o),
    .tx_o         (tx_o)
  );

  sfe_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .cfg_i  (cfg_q),
    .rx_i   (rx_i),
    .idle_o (rx_idle),
    .valid_o(rx_valid_o),
    .data_o (rx_data_o),
    .perr_o (rx_perr_o),
    .ferr_o (rx_ferr_o)
  );
endmodule

// File: rtl/sfe_checks.sv
module sfe_checks
  import sfe_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic tx_o,
  input logic tx_ready_o,
  input logic err_o,
  input logic err_clr_i,
  input logic rx_valid_o,
  input logic rx_perr_o,
  input logic rx_ferr_o,
  input cfg_t cfg_q,
  input logic cfg_bad,
  input logic latch_en
);
  a_r11_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> tx_o);

  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_ready_o && $past(!tx_ready_o)) |-> $stable(cfg_q));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

  a_r6_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(cfg_bad && latch_en));

  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r8_flags_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_perr_o || rx_ferr_o) |-> rx_valid_o);
endmodule

bind serial_fmt_engine sfe_checks u_sfe_checks (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_o      (tx_o),
  .tx_ready_o(tx_ready_o),
  .err_o     (err_o),
  .err_clr_i (err_clr_i),
  .rx_valid_o(rx_valid_o),
  .rx_perr_o (rx_perr_o),
  .rx_ferr_o (rx_ferr_o),
  .cfg_q     (cfg_q),
  .cfg_bad   (cfg_bad),
  .latch_en  (latch_en)
);

// File: tb/serial_fmt_engine_bench.sv
module serial_fmt_engine_bench;
  localparam int SDIV = 2;
  localparam int TDIV = 20;

  logic        clk = 0, rst_n = 0;
  logic [15:0] setup = 16'h0804, delay = 16'h0000;
  logic        clr = 0, tx_valid = 0, loop_en = 1, rx_drv = 1;
  logic [7:0]  tx_data = 0;
  logic        tx_ready, tx_line, rx_valid, rx_perr, rx_ferr, err;
  logic [7:0]  rx_data;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  logic        got;
  logic [7:0]  got_d;
  logic        got_p, got_f;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_fmt_engine #(.SAMPLE_DIV(SDIV), .TICK_DIV(TDIV)) u_serial_fmt_engine (
    .clk_i(clk), .rst_ni(rst_n), .setup_i(setup), .delay_i(delay), .err_clr_i(clr),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready), .tx_o(tx_line),
    .rx_i(loop_en ? tx_line : rx_drv), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr), .err_o(err)
  );

  always @(negedge clk) if (rx_valid) begin
    got <= 1; got_d <= rx_data; got_p <= rx_perr; got_f <= rx_ferr;
  end

  // rate(8) fmt(8) data(8) err(1)
  localparam logic [24:0] VEC [14] = '{
    {8'h04, 8'h00, 8'h5A, 1'b0}, {8'h04, 8'h01, 8'h33, 1'b0}, {8'h03, 8'h02, 8'h7F, 1'b0},
    {8'h04, 8'h03, 8'h01, 1'b0}, {8'h02, 8'h04, 8'h40, 1'b0}, {8'h04, 8'h05, 8'h2C, 1'b0},
    {8'h04, 8'h06, 8'hA5, 1'b0}, {8'h03, 8'h07, 8'h80, 1'b0}, {8'h04, 8'h08, 8'hFF, 1'b0},
    {8'h04, 8'h09, 8'h96, 1'b0}, {8'h01, 8'h0A, 8'h3C, 1'b0}, {8'h00, 8'h0B, 8'hC3, 1'b0},
    {8'h04, 8'h0C, 8'hD2, 1'b1}, {8'h07, 8'h08, 8'h4E, 1'b1}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
  endtask

  // expected frame from rate/format code
  task automatic expect_frame(input logic [7:0] rate, input logic [7:0] fmt, input logic [7:0] d,
                              output logic [11:0] bits, output int nb, output int bp,
                              output logic [7:0] rxd);
    int nd, ns, pm, r, m;
    logic p;
    r  = (rate <= 4) ? int'(rate) : 3;
    bp = (16 * SDIV) << (4 - r);
    if (fmt > 11) begin nd = 7; ns = 2; pm = 0; end
    else begin
      nd = (fmt < 6) ? 7 : 8;
      m  = int'(fmt) % 6;
      ns = (m < 3) ? 1 : 2;
      pm = m % 3;
    end
    rxd = (nd == 7) ? {1'b0, d[6:0]} : d;
    p = (^rxd) ^ (pm == 1);
    bits = '1;
    bits[0] = 0;
    for (int i = 0; i < nd; i++) bits[1 + i] = d[i];
    if (pm != 2) bits[1 + nd] = p;
    nb = 1 + nd + (pm != 2 ? 1 : 0) + ns;
  endtask

  task automatic send_tx(input logic [7:0] d, output int acc);
    @(negedge clk); tx_valid = 1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); acc = cyc; tx_valid = 0;
  endtask

  task automatic capture(input int nb, input int bp, output logic [11:0] bits, output int len);
    int t0, guard;
    bits = '1;
    guard = 0;
    while (tx_line && guard < 30000) begin @(negedge clk); guard++; end
    t0 = cyc;
    wait_n(bp / 2);
    for (int i = 0; i < nb; i++) begin
      bits[i] = tx_line;
      if (i != nb - 1) wait_n(bp);
    end
    guard = 0;
    while (!tx_ready && guard < 30000) begin @(negedge clk); guard++; end
    len = cyc - t0;
  endtask

  task automatic drive_rx(input logic [11:0] bits, input int nb, input int bp, input int glitch);
    for (int i = 0; i < nb; i++) begin
      rx_drv = bits[i];
      if (i == glitch) begin
        wait_n(bp / 2 - 1); rx_drv = ~bits[i]; wait_n(2); rx_drv = bits[i]; wait_n(bp / 2 - 1);
      end else wait_n(bp);
    end
    rx_drv = 1;
    wait_n(2 * bp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] eb, cb;
    logic [7:0]  exd;
    int nb, bp, len, acc, dl;
    got = 0;
    wait_n(3);
    // R11 reset state
    check(tx_line === 1'b1, "R11 reset tx_o", tx_line, 1);
    check(tx_ready === 1'b1, "R11 reset tx_ready_o", tx_ready, 1);
    check(err === 1'b0, "R11 reset err_o", err, 0);
    check(rx_valid === 1'b0, "R11 reset rx_valid_o", rx_valid, 0);
    rst_n = 1;
    wait_n(4);

    // R1 R2 R3 table walk with loopback
    foreach (VEC[k]) begin
      setup = {VEC[k][16:9], VEC[k][24:17]};
      delay = 16'h0000;
      wait_n(4);
      pulse_clr();
      wait_n(4);
      check(err === VEC[k][0], $sformatf("R1/R3 err vec%0d", k), err, VEC[k][0]);
      expect_frame(VEC[k][24:17], VEC[k][16:9], VEC[k][8:1], eb, nb, bp, exd);
      got = 0;
      send_tx(VEC[k][8:1], acc);
      capture(nb, bp, cb, len);
      check(cb == eb, $sformatf("R2 frame bits vec%0d", k), cb, eb);
      check(len >= nb * bp - 3 && len <= nb * bp + 3, $sformatf("R1 frame length vec%0d", k), len, nb * bp);
      wait_n(bp);
      check(got && got_d == exd && !got_p && !got_f, $sformatf("R11 loopback data vec%0d", k),
            {got, got_p, got_f, got_d}, {3'b100, exd});
    end

    // R10 setup change during a frame
    setup = 16'h0804; wait_n(4); pulse_clr(); wait_n(4);
    expect_frame(8'h04, 8'h08, 8'hC5, eb, nb, bp, exd);
    got = 0;
    send_tx(8'hC5, acc);
    fork
      capture(nb, bp, cb, len);
      begin wait_n(60); setup = 16'h0300; end
    join
    check(cb == eb, "R10 frame kept during setup change", cb, eb);
    check(len >= nb * bp - 3 && len <= nb * bp + 3, "R10 length kept", len, nb * bp);
    setup = 16'h0804; wait_n(3 * bp);

    // R4 BCD delay
    delay = 16'h0003; wait_n(4);
    send_tx(8'h11, acc);
    while (tx_line) @(negedge clk);
    dl = cyc - acc;
    check(dl >= 3 * TDIV - 2 && dl <= 3 * TDIV + 6, "R4 delay 3 units", dl, 3 * TDIV);
    while (!tx_ready) @(negedge clk);
    delay = 16'h0012; wait_n(4);
    send_tx(8'h22, acc);
    while (tx_line) @(negedge clk);
    dl = cyc - acc;
    check(dl >= 12 * TDIV - 2 && dl <= 12 * TDIV + 6, "R4 delay 12 units", dl, 12 * TDIV);
    while (!tx_ready) @(negedge clk);
    check(err === 1'b0, "R4 legal delay no error", err, 0);

    // R5 non-BCD delay
    delay = 16'h00A0; wait_n(4);
    check(err === 1'b1, "R5 non-BCD sets err", err, 1);
    send_tx(8'h33, acc);
    while (tx_line) @(negedge clk);
    dl = cyc - acc;
    check(dl <= 6, "R5 non-BCD zero delay", dl, 0);
    while (!tx_ready) @(negedge clk);

    // R6 sticky flag
    delay = 16'h0000; wait_n(20);
    check(err === 1'b1, "R6 err held after legal setup", err, 1);
    pulse_clr(); wait_n(2);
    check(err === 1'b0, "R6 err cleared", err, 0);

    // R7 R8 R9 receiver driven directly, 7E1 at 19200
    setup = 16'h0004; wait_n(4);
    loop_en = 0;
    expect_frame(8'h04, 8'h00, 8'h35, eb, nb, bp, exd);
    got = 0;
    drive_rx(eb, nb, bp, 3);
    check(got && got_d == 8'h35 && !got_p && !got_f, "R7 glitched bit voted out",
          {got, got_p, got_f, got_d}, {3'b100, 8'h35});
    cb = eb; cb[8] = ~eb[8];
    got = 0;
    drive_rx(cb, nb, bp, -1);
    check(got && got_p && !got_f, "R7 parity error flagged", {got, got_p, got_f}, 3'b110);
    cb = eb; cb[9] = 0;
    got = 0;
    drive_rx(cb, nb, bp, -1);
    check(got && got_f, "R8 framing error flagged", {got, got_f}, 2'b11);
    wait_n(2 * bp);
    got = 0;
    rx_drv = 0; wait_n(8); rx_drv = 1;
    wait_n(3 * bp);
    check(!got, "R9 short start pulse rejected", got, 0);
    expect_frame(8'h04, 8'h00, 8'h4B, eb, nb, bp, exd);
    drive_rx(eb, nb, bp, -1);
    check(got && got_d == 8'h4B && !got_p, "R9 recovery after rejected start", {got, got_d}, {1'b1, 8'h4B});

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule